// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for each beat of a synchronous DRAM read or write burst. A mode word is loaded once to program the burst length, the burst ordering and whether writes are forced to a single location. Each start strobe then supplies a starting column. From the next clock the block presents one column per cycle, along with a valid flag and a flag on the final beat.

For short bursts the low column bits move inside an aligned block, either by a wrapping increment or by an XOR with the beat index. The upper bits stay fixed. A full-page burst walks the whole row and wraps from the top column to column 0. It continues until it is terminated. A load that holds a reserved field is refused: the stored mode is kept and an error pulse is raised. A new start strobe always takes over from a burst that is still running.

Top module: `burst_col_seq`

## Requirements
- R1: The clock edge that samples start_i makes valid_o high and sets col_o to start_col_i. Each later edge advances the burst by one beat.
- R2: Sequential type (mode bit 3 = 0). Beat k takes the low log2(L) bits as (start low bits + k) mod L, where L is the burst length. The higher bits keep the value of the start column. Example: length 4 from 2 gives 2,3,0,1.
- R3: Interleaved type (mode bit 3 = 1). Beat k takes the low log2(L) bits as (start low bits) XOR k. The higher bits are fixed. Example: length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: Mode bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page. last_o is high on beat L-1. valid_o falls on the next edge unless a start arrives.
- R5: With length 1 the burst is a single beat at the start column, whatever mode bit 3 holds.
- R6: A full-page burst (code 111, sequential only) raises the column by one per beat and wraps from 2^COL_W-1 to 0. It never raises last_o and runs until it is terminated or restarted.
- R7: When mode bit 9 is 1, a burst started with write_i = 1 has length 1. A burst started with write_i = 0 keeps the programmed length.
- R8: A load is rejected if any of these hold: length code 100, 101 or 110; length 111 with bit 3 = 1; bits [6:4] other than 010 or 011; bits [8:7] not equal to 00. On rejection mode_err_o is high for the one cycle after the load, and later bursts follow the previous mode.
- R9: A load accepted at an edge takes effect for start strobes at later edges. A start at the same edge uses the earlier mode.
- R10: term_i sampled during a burst makes valid_o low from the next edge. A start at the same edge overrides the terminate.
- R11: A start during an active burst abandons the old burst. The new sequence begins on the next edge.
- R12: After reset valid_o, last_o and mode_err_o are low. The mode is length 1, sequential, with writes following the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Load strobe for the mode word |
| mode_word_i | input | 10 | Mode word: [2:0] length, [3] type, [6:4] latency, [8:7] operating mode, [9] single-write |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | COL_W | Starting column |
| write_i | input | 1 | Burst is a write (sampled with start_i) |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | col_o holds a live beat |
| last_o | output | 1 | Current beat is the final one |
| mode_err_o | output | 1 | Pulse: the previous load was rejected |

## Verification
The assertions assume that the strobes are clean single-bit levels sampled at the clock edge. They also assume a start column within the row; every COL_W-bit value satisfies this. The assertions make no assumption about how the strobes overlap. The stimulus drives every input on the falling edge and leaves it stable across the rising edge. It includes load, start and terminate strobes that coincide with each other or fall in the middle of a burst, so every priority case occurs while the reference model tracks it.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] op;
    logic [2:0] cl;
    logic       ilv;
    logic [2:0] blen;
  } mode_t;

  typedef struct packed {
    logic       wr_single;
    logic       ilv;
    logic [2:0] blen;
  } cfg_t;

  localparam logic [2:0] BLEN_PAGE = 3'b111;

  function automatic logic mode_ok(mode_t m);
    logic len_ok, cl_ok;
    len_ok = (m.blen inside {3'b000, 3'b001, 3'b010, 3'b011}) ||
             (m.blen == BLEN_PAGE && !m.ilv);
    cl_ok  = (m.cl == 3'b010) || (m.cl == 3'b011);
    return len_ok && cl_ok && (m.op == 2'b00);
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import sdram_burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output cfg_t              cfg_o,
  output logic              err_o
);
  mode_t w;
  assign w = mode_t'(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= load_i && !mode_ok(w);
      if (load_i && mode_ok(w))
        cfg_o <= '{wr_single: w.wr_single, ilv: w.ilv, blen: w.blen};
    end
  end

  // R8: a rejected load leaves the stored mode untouched
  a_r8_keep_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(cfg_o));
  // R8: the error pulse only follows a load
  a_r8_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(load_i));
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;
  assign low = ilv_i ? (base_i ^ beat_i) : (base_i + beat_i);

  // masked bits move within the block, the rest hold the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? low[b] : base_i[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              write_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              mode_err_o
);
  localparam logic [COL_W-1:0] MASK_PAGE = {COL_W{1'b1}};

  cfg_t cfg;
  logic [COL_W-1:0] base_q, beat_q, mask_q, mask_d;
  logic             ilv_q, full_q, valid_q, single_wr;

  burst_mode_reg i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .word_i (mode_word_i),
    .cfg_o  (cfg),
    .err_o  (mode_err_o)
  );

  assign single_wr = write_i && cfg.wr_single;

  always_comb begin
    mask_d = '0;
    if (!single_wr) begin
      unique case (cfg.blen)
        3'b001:    mask_d = COL_W'(1);
        3'b010:    mask_d = COL_W'(3);
        3'b011:    mask_d = COL_W'(7);
        BLEN_PAGE: mask_d = MASK_PAGE;
        default:   mask_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= mask_d;
      ilv_q   <= cfg.ilv;
      full_q  <= !single_wr && (cfg.blen == BLEN_PAGE);
    end else if (valid_q) begin
      if (term_i || last_o) valid_q <= 1'b0;
      else                  beat_q  <= beat_q + 1'b1;
    end
  end

  burst_col_calc #(.COL_W(COL_W)) i_calc (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign valid_o = valid_q;
  assign last_o  = valid_q && !full_q && (beat_q == mask_q);

  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i));
  a_r4_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o && !start_i |=> !valid_o);
  a_r4_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  a_r10_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && term_i && !start_i |=> !valid_o);
  a_r2_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !term_i |=>
      valid_o && ((col_o & ~mask_q) == $past(col_o & ~mask_q)));
  a_r6_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && !start_i && !term_i |=>
      valid_o && !last_o && col_o == COL_W'($past(col_o) + 1'b1));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, start = 1'b0, wr = 1'b0, term = 1'b0;
  logic [9:0] word = '0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col;
  logic valid, last, err;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(load), .mode_word_i(word),
    .start_i(start), .start_col_i(start_col), .write_i(wr), .term_i(term),
    .col_o(col), .valid_o(valid), .last_o(last), .mode_err_o(err));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R12";
  bit chk_en = 1'b0;

  // reference model
  bit m_act = 0, m_ilv = 0, m_full = 0, m_err = 0;
  int m_k = 0, m_s = 0, m_L = 1;
  logic [9:0] m_mode = 10'h020;

  function automatic logic [9:0] mw(int lc, int t, int cl, int ws);
    return {ws[0], 2'b00, cl[2:0], t[0], lc[2:0]};
  endfunction

  function automatic bit word_ok(logic [9:0] w);
    bit ok = 1'b1;
    if (w[2:0] == 3'd4 || w[2:0] == 3'd5 || w[2:0] == 3'd6) ok = 1'b0;
    if (w[2:0] == 3'd7 && w[3]) ok = 1'b0;
    if (w[6:4] != 3'd2 && w[6:4] != 3'd3) ok = 1'b0;
    if (w[8:7] != 2'd0) ok = 1'b0;
    return ok;
  endfunction

  function automatic int len_of(logic [9:0] w);
    case (w[2:0])
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int lo, base;
    if (m_full) return (m_s + m_k) % PAGE;
    lo   = m_s % m_L;
    base = m_s - lo;
    if (m_ilv) return base + (lo ^ m_k);
    return base + ((lo + m_k) % m_L);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_mode = 10'h020; m_err = 0;
    end else begin
      bit nerr;
      bit sw;
      nerr = 0;
      sw = wr && m_mode[9];
      if (start) begin
        m_act = 1; m_k = 0; m_s = start_col;
        m_full = (m_mode[2:0] == 3'd7) && !sw;
        m_L = sw ? 1 : len_of(m_mode);
        m_ilv = m_mode[3];
      end else if (m_act) begin
        if (term || (!m_full && m_k == m_L - 1)) m_act = 0;
        else m_k = m_k + 1;
      end
      if (load) begin
        if (word_ok(word)) m_mode = word;
        else nerr = 1;
      end
      m_err = nerr;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk(valid == m_act, "valid_o", int'(valid), int'(m_act));
      chk(err == m_err, "mode_err_o", int'(err), int'(m_err));
      if (m_act) begin
        chk(int'(col) == exp_col(), "col_o", int'(col), exp_col());
        chk(last == (!m_full && m_k == m_L - 1), "last_o", int'(last),
            int'(!m_full && m_k == m_L - 1));
      end else begin
        chk(last == 1'b0, "last_o idle", int'(last), 0);
      end
    end
  end

  task automatic do_load(logic [9:0] w);
    @(negedge clk); load = 1'b1; word = w;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_start(int c, bit w);
    @(negedge clk); start = 1'b1; start_col = COL_W'(c); wr = w;
    @(negedge clk); start = 1'b0; wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    chk(valid == 1'b0, "R12 valid_o in reset", int'(valid), 0);
    chk(last == 1'b0, "R12 last_o in reset", int'(last), 0);
    chk(err == 1'b0, "R12 mode_err_o in reset", int'(err), 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    cur_req = "R12 R7";
    do_start(13, 1'b0);
    wait_idle();
    do_start(14, 1'b1);
    wait_idle();

    // R1 R2 R3 R4 R5: every length, type and offset
    for (int t = 0; t < 2; t++) begin
      for (int lc = 0; lc < 4; lc++) begin
        if (lc == 0) cur_req = "R5 R1";
        else cur_req = t ? "R3 R4 R1" : "R2 R4 R1";
        do_load(mw(lc, t, 2, 0));
        for (int s = 0; s < 8; s++) begin
          do_start((s * 37 + 8 * lc + 16 * t) % PAGE, 1'b0);
          wait_idle();
        end
      end
    end

    // R7: single write override
    cur_req = "R7";
    do_load(mw(3, 0, 3, 1));
    do_start(100, 1'b1);
    wait_idle();
    do_start(101, 1'b0);
    wait_idle();
    do_load(mw(2, 1, 3, 1));
    do_start(102, 1'b1);
    wait_idle();

    // R6: full page wrap, terminated
    cur_req = "R6 R10";
    do_load(mw(7, 0, 2, 0));
    do_start(PAGE - 3, 1'b0);
    repeat (PAGE + 4) @(negedge clk);
    term = 1'b1;
    @(negedge clk); term = 1'b0;
    wait_idle();

    // R10: terminate mid burst, terminate with start
    cur_req = "R10";
    do_load(mw(3, 0, 2, 0));
    do_start(8, 1'b0);
    @(negedge clk); term = 1'b1;
    @(negedge clk); term = 1'b0;
    wait_idle();
    cur_req = "R10 R11";
    do_start(20, 1'b0);
    @(negedge clk); start = 1'b1; term = 1'b1; start_col = COL_W'(45);
    @(negedge clk); start = 1'b0; term = 1'b0;
    wait_idle();

    // R11: restart mid burst
    cur_req = "R11";
    do_load(mw(3, 1, 2, 0));
    do_start(3, 1'b0);
    repeat (2) @(negedge clk);
    do_start(33, 1'b0);
    wait_idle();

    // R8: reserved words rejected, old mode (length 8 interleaved) kept
    cur_req = "R8";
    do_load(mw(4, 0, 2, 0)); do_start(50, 1'b0); wait_idle();
    do_load(mw(5, 0, 2, 0)); do_start(51, 1'b0); wait_idle();
    do_load(mw(6, 1, 3, 0)); do_start(52, 1'b0); wait_idle();
    do_load(mw(7, 1, 2, 0)); do_start(53, 1'b0); wait_idle();
    do_load(mw(1, 0, 0, 0)); do_start(54, 1'b0); wait_idle();
    do_load(mw(1, 0, 4, 0)); do_start(55, 1'b0); wait_idle();
    do_load(mw(1, 0, 2, 0) | 10'h080); do_start(56, 1'b0); wait_idle();
    do_load(mw(1, 0, 3, 0) | 10'h100); do_start(57, 1'b0); wait_idle();

    // R9: load and start at the same edge
    cur_req = "R9";
    @(negedge clk); load = 1'b1; word = mw(2, 0, 3, 0);
    start = 1'b1; start_col = COL_W'(61);
    @(negedge clk); load = 1'b0; start = 1'b0;
    wait_idle();
    do_start(62, 1'b0);
    wait_idle();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule